// File: doc/BRIEF.md
# Instruction dispatch admission controller

This block is the gate between the decode queue and the scheduler. On each clock it looks at the instruction at the head of the queue and decides whether that instruction may leave. It compares the instruction's micro-op count, its count of result registers and its need for scheduler-buffer entries against the free counts reported by the reorder buffer, the physical register pool and the scheduler buffer. When the instruction may leave, the block raises a one-clock dispatch strobe and drives the amounts that each of the three structures must allocate. When it may not, the block reports why.

Dispatch is grouped into dispatch cycles. Each dispatch cycle offers `DISP_W` micro-op slots, and several instructions may share one cycle. The upstream logic opens each new cycle by pulsing `cyc_begin`. An instruction wider than `DISP_W` may still leave when all slots of the cycle are free. The micro-ops that did not fit are held as a carry-over count, and that count eats into the slots of the following cycles.

A group-phase state machine tracks the remaining slots. Its states are `GRP_FULL` (all slots free, nothing carried), `GRP_PART` (some slots used), `GRP_EMPTY` (no slots left, nothing carried) and `GRP_CARRY` (a wide instruction's excess is still pending). Its transitions are: the refill on `cyc_begin`, the consumption on a dispatch, and holding on a stall or an idle clock. After each transition the next state is chosen from the resulting slot and carry counts.

Top module: `dispatch_admit`

## Requirements
- R1: `disp_fire` is high only when all of these hold: `head_valid` is high, the slot rule of R4 passes, `rob_free >= head_uops`, `prf_free >= head_dsts` and `sch_free >= head_sched`. When all of them hold, `disp_fire` is high in that same clock. Equality is enough to dispatch.
- R2: When `head_valid` is high, the slot rule passes and a resource is short, `stall_code` names the first failing check, taken in the order reorder buffer (code 1), register pool (code 2), scheduler buffer (code 3). In every other case `stall_code` is 0.
- R3: While `disp_fire` is high, `alloc_rob`, `alloc_prf` and `alloc_sch` equal `head_uops`, `head_dsts` and `head_sched`. While `disp_fire` is low, all three are 0.
- R4: An instruction passes the slot rule when `head_uops` is not greater than the remaining slots, or when the remaining slots equal `DISP_W`. A dispatch lowers the remaining slots by `head_uops`, flooring at 0. Further instructions in the same dispatch cycle use what is left.
- R5: A dispatched instruction with more micro-ops than remaining slots adds the excess to the carry-over. At `cyc_begin` the remaining slots become `DISP_W` minus the carry-over, floored at 0, and the carry-over drops by the amount it covered. These new values apply to the instruction evaluated in that same clock.
- R6: Each nonzero `stall_code` raises its own counter by one at the clock edge. Counter `stall_cnt_rob` counts code 1, `stall_cnt_prf` counts code 2 and `stall_cnt_sch` counts code 3. Each counter saturates at all ones.
- R7: After reset the remaining slots equal `DISP_W`, the carry-over is 0 and all stall counters are 0. An instruction of up to `DISP_W` micro-ops, or a wider one, can therefore leave without `cyc_begin`.
- R8: A stalled instruction allocates nothing and uses no slots. Re-evaluated on the next clock, it sees the same remaining slots.
- R9: With `head_valid` low there is no dispatch and no stall code, no counter changes, and no slots are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_begin | input | 1 | Opens a new dispatch cycle in this clock |
| head_valid | input | 1 | Queue head holds an instruction |
| head_uops | input | NEED_W | Micro-op count of the head instruction |
| head_dsts | input | NEED_W | Result registers to rename |
| head_sched | input | NEED_W | Scheduler-buffer entries needed |
| rob_free | input | FREE_W | Free reorder-buffer entries |
| prf_free | input | FREE_W | Free physical registers |
| sch_free | input | FREE_W | Free scheduler-buffer entries |
| disp_fire | output | 1 | Head instruction dispatches this clock |
| alloc_rob | output | NEED_W | Reorder-buffer entries to allocate |
| alloc_prf | output | NEED_W | Physical registers to allocate |
| alloc_sch | output | NEED_W | Scheduler entries to allocate |
| stall_code | output | 2 | First failing resource, 0 when none |
| stall_cnt_rob | output | CNT_W | Reorder-buffer stall count |
| stall_cnt_prf | output | CNT_W | Register-pool stall count |
| stall_cnt_sch | output | CNT_W | Scheduler-buffer stall count |

## Verification
The bench builds the block with `DISP_W` = 4, `NEED_W` = 5, `FREE_W` = 7 and `CNT_W` = 4. With a width of four, a five-micro-op or ten-micro-op instruction produces a carry-over. The ten-micro-op case takes more than one refill to drain, so the saturating branch of the refill and the partial branch are both exercised within a few vectors. The 4-bit counters reach their saturation value of 15 after a short run of held stalls, which makes the saturating behaviour of R6 reachable in a short run.

// File: rtl/dap_pkg.sv
package dap_pkg;

    typedef enum logic [1:0] {
        GRP_FULL  = 2'd0,
        GRP_PART  = 2'd1,
        GRP_EMPTY = 2'd2,
        GRP_CARRY = 2'd3
    } grp_state_e;

    typedef enum logic [1:0] {
        STALL_NONE = 2'd0,
        STALL_ROB  = 2'd1,
        STALL_PRF  = 2'd2,
        STALL_SCH  = 2'd3
    } stall_e;

    localparam int NUM_REASONS = 3;

endpackage

// File: rtl/dap_slot_tracker.sv
module dap_slot_tracker
    import dap_pkg::*;
#(
    parameter int DISP_W = 4,
    parameter int NEED_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_begin,
    input  logic              fire,
    input  logic [NEED_W-1:0] uops,
    output logic              slot_ok
);

    localparam int                SLOT_W  = $clog2(DISP_W + 1);
    localparam logic [NEED_W-1:0] WIDTH_N = NEED_W'(DISP_W);
    localparam logic [SLOT_W-1:0] WIDTH_S = SLOT_W'(DISP_W);

    grp_state_e        state_q, state_n;
    logic [SLOT_W-1:0] slots_q, slots_n;
    logic [NEED_W-1:0] carry_q, carry_n;

    logic [SLOT_W-1:0] eff_slots;
    logic [NEED_W-1:0] eff_carry;
    logic [NEED_W-1:0] eff_slots_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRP_FULL;
            slots_q <= WIDTH_S;
            carry_q <= '0;
        end else begin
            state_q <= state_n;
            slots_q <= slots_n;
            carry_q <= carry_n;
        end
    end

    // Slots and carry seen by the instruction in this clock
    always_comb begin
        eff_carry = carry_q;
        eff_slots = '0;
        if (cyc_begin) begin
            if (carry_q >= WIDTH_N) begin
                eff_slots = '0;
                eff_carry = carry_q - WIDTH_N;
            end else begin
                eff_slots = SLOT_W'(WIDTH_N - carry_q);
                eff_carry = '0;
            end
        end else begin
            unique case (state_q)
                GRP_FULL:  eff_slots = WIDTH_S;
                GRP_PART:  eff_slots = slots_q;
                GRP_EMPTY: eff_slots = '0;
                GRP_CARRY: eff_slots = '0;
                default:   eff_slots = '0;
            endcase
        end
        eff_slots_n = NEED_W'(eff_slots);
        slot_ok     = (uops <= eff_slots_n) || (eff_slots == WIDTH_S);
    end

    // Consumption and next state
    always_comb begin
        slots_n = eff_slots;
        carry_n = eff_carry;
        if (fire) begin
            if (uops >= eff_slots_n) begin
                slots_n = '0;
                carry_n = eff_carry + (uops - eff_slots_n);
            end else begin
                slots_n = eff_slots - SLOT_W'(uops);
            end
        end
        if (carry_n != '0)          state_n = GRP_CARRY;
        else if (slots_n == WIDTH_S) state_n = GRP_FULL;
        else if (slots_n == '0)      state_n = GRP_EMPTY;
        else                         state_n = GRP_PART;
    end

endmodule

// File: rtl/dap_res_check.sv
module dap_res_check
    import dap_pkg::*;
#(
    parameter int NEED_W = 5,
    parameter int FREE_W = 7
) (
    input  logic [NEED_W-1:0] uops,
    input  logic [NEED_W-1:0] dsts,
    input  logic [NEED_W-1:0] sched,
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] prf_free,
    input  logic [FREE_W-1:0] sch_free,
    output logic              res_ok,
    output stall_e            fail_code
);

    logic rob_ok, prf_ok, sch_ok;

    always_comb begin
        rob_ok = rob_free >= FREE_W'(uops);
        prf_ok = prf_free >= FREE_W'(dsts);
        sch_ok = sch_free >= FREE_W'(sched);
        res_ok = rob_ok && prf_ok && sch_ok;
        // fixed priority: reorder buffer, register pool, scheduler
        if (!rob_ok)      fail_code = STALL_ROB;
        else if (!prf_ok) fail_code = STALL_PRF;
        else if (!sch_ok) fail_code = STALL_SCH;
        else              fail_code = STALL_NONE;
    end

endmodule

// File: rtl/dap_stall_ctr.sv
module dap_stall_ctr
    import dap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  stall_e                              code,
    output logic [NUM_REASONS-1:0][CNT_W-1:0]   cnt
);

    for (genvar g = 0; g < NUM_REASONS; g++) begin : g_reason
        logic hit;
        assign hit = (code == stall_e'(2'(g + 1)));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cnt[g] <= '0;
            else if (hit && (cnt[g] != '1))
                cnt[g] <= cnt[g] + 1'b1;
        end
    end

endmodule

// File: rtl/dispatch_admit.sv
module dispatch_admit
    import dap_pkg::*;
#(
    parameter int DISP_W = 4,
    parameter int NEED_W = 5,
    parameter int FREE_W = 7,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_begin,
    input  logic              head_valid,
    input  logic [NEED_W-1:0] head_uops,
    input  logic [NEED_W-1:0] head_dsts,
    input  logic [NEED_W-1:0] head_sched,
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] prf_free,
    input  logic [FREE_W-1:0] sch_free,
    output logic              disp_fire,
    output logic [NEED_W-1:0] alloc_rob,
    output logic [NEED_W-1:0] alloc_prf,
    output logic [NEED_W-1:0] alloc_sch,
    output logic [1:0]        stall_code,
    output logic [CNT_W-1:0]  stall_cnt_rob,
    output logic [CNT_W-1:0]  stall_cnt_prf,
    output logic [CNT_W-1:0]  stall_cnt_sch
);

    logic                              slot_ok;
    logic                              res_ok;
    stall_e                            fail_code;
    stall_e                            code_q;
    logic [NUM_REASONS-1:0][CNT_W-1:0] cnt;

    dap_slot_tracker #(.DISP_W(DISP_W), .NEED_W(NEED_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_begin (cyc_begin),
        .fire      (disp_fire),
        .uops      (head_uops),
        .slot_ok   (slot_ok)
    );

    dap_res_check #(.NEED_W(NEED_W), .FREE_W(FREE_W)) u_check (
        .uops      (head_uops),
        .dsts      (head_dsts),
        .sched     (head_sched),
        .rob_free  (rob_free),
        .prf_free  (prf_free),
        .sch_free  (sch_free),
        .res_ok    (res_ok),
        .fail_code (fail_code)
    );

    dap_stall_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (code_q),
        .cnt   (cnt)
    );

    always_comb begin
        disp_fire = head_valid && slot_ok && res_ok;
        code_q    = (head_valid && slot_ok) ? fail_code : STALL_NONE;
        alloc_rob = disp_fire ? head_uops  : '0;
        alloc_prf = disp_fire ? head_dsts  : '0;
        alloc_sch = disp_fire ? head_sched : '0;
    end

    assign stall_code    = code_q;
    assign stall_cnt_rob = cnt[0];
    assign stall_cnt_prf = cnt[1];
    assign stall_cnt_sch = cnt[2];

endmodule

// File: rtl/dap_checker.sv
module dap_checker #(
    parameter int DISP_W = 4,
    parameter int NEED_W = 5,
    parameter int FREE_W = 7,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cyc_begin,
    input logic              head_valid,
    input logic [NEED_W-1:0] head_uops,
    input logic [NEED_W-1:0] head_dsts,
    input logic [NEED_W-1:0] head_sched,
    input logic [FREE_W-1:0] rob_free,
    input logic [FREE_W-1:0] prf_free,
    input logic [FREE_W-1:0] sch_free,
    input logic              disp_fire,
    input logic [NEED_W-1:0] alloc_rob,
    input logic [NEED_W-1:0] alloc_prf,
    input logic [NEED_W-1:0] alloc_sch,
    input logic [1:0]        stall_code,
    input logic [CNT_W-1:0]  stall_cnt_rob,
    input logic [CNT_W-1:0]  stall_cnt_prf,
    input logic [CNT_W-1:0]  stall_cnt_sch
);

    AST_ROB_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> FREE_W'(alloc_rob) <= rob_free); // R1
    AST_PRF_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> FREE_W'(alloc_prf) <= prf_free); // R1
    AST_SCH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> FREE_W'(alloc_sch) <= sch_free); // R1
    AST_NO_CODE_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> stall_code == 2'd0); // R2
    AST_ALLOC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> (alloc_rob == head_uops && alloc_prf == head_dsts
                       && alloc_sch == head_sched)); // R3
    AST_IDLE_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_fire |-> (alloc_rob == '0 && alloc_prf == '0 && alloc_sch == '0)); // R3
    AST_WIDE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_fire && head_uops > NEED_W'(DISP_W))
        |=> (cyc_begin || !disp_fire || head_uops == '0)); // R5
    AST_ROB_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_code == 2'd1 && stall_cnt_rob != '1)
        |=> stall_cnt_rob == CNT_W'($past(stall_cnt_rob) + 1'b1)); // R6
    AST_ROB_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_code != 2'd1) |=> $stable(stall_cnt_rob)); // R6
    AST_PRF_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_code != 2'd2) |=> $stable(stall_cnt_prf)); // R6
    AST_SCH_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_code != 2'd3) |=> $stable(stall_cnt_sch)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |-> (!disp_fire && stall_code == 2'd0)); // R9

endmodule

bind dispatch_admit dap_checker #(
    .DISP_W(DISP_W), .NEED_W(NEED_W), .FREE_W(FREE_W), .CNT_W(CNT_W)
) u_dap_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_begin     (cyc_begin),
    .head_valid    (head_valid),
    .head_uops     (head_uops),
    .head_dsts     (head_dsts),
    .head_sched    (head_sched),
    .rob_free      (rob_free),
    .prf_free      (prf_free),
    .sch_free      (sch_free),
    .disp_fire     (disp_fire),
    .alloc_rob     (alloc_rob),
    .alloc_prf     (alloc_prf),
    .alloc_sch     (alloc_sch),
    .stall_code    (stall_code),
    .stall_cnt_rob (stall_cnt_rob),
    .stall_cnt_prf (stall_cnt_prf),
    .stall_cnt_sch (stall_cnt_sch)
);

// File: tb/tb_dispatch_admit.sv
module tb_dispatch_admit;

    localparam int DISP_W = 4;
    localparam int NEED_W = 5;
    localparam int FREE_W = 7;
    localparam int CNT_W  = 4;
    localparam int NVEC   = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cyc_begin = 1'b0;
    logic              head_valid = 1'b0;
    logic [NEED_W-1:0] head_uops = '0;
    logic [NEED_W-1:0] head_dsts = '0;
    logic [NEED_W-1:0] head_sched = '0;
    logic [FREE_W-1:0] rob_free = '0;
    logic [FREE_W-1:0] prf_free = '0;
    logic [FREE_W-1:0] sch_free = '0;
    logic              disp_fire;
    logic [NEED_W-1:0] alloc_rob, alloc_prf, alloc_sch;
    logic [1:0]        stall_code;
    logic [CNT_W-1:0]  stall_cnt_rob, stall_cnt_prf, stall_cnt_sch;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dispatch_admit #(
        .DISP_W(DISP_W), .NEED_W(NEED_W), .FREE_W(FREE_W), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cyc_begin(cyc_begin), .head_valid(head_valid),
        .head_uops(head_uops), .head_dsts(head_dsts), .head_sched(head_sched),
        .rob_free(rob_free), .prf_free(prf_free), .sch_free(sch_free),
        .disp_fire(disp_fire), .alloc_rob(alloc_rob), .alloc_prf(alloc_prf),
        .alloc_sch(alloc_sch), .stall_code(stall_code),
        .stall_cnt_rob(stall_cnt_rob), .stall_cnt_prf(stall_cnt_prf),
        .stall_cnt_sch(stall_cnt_sch)
    );

    // {beg, valid, uops, dsts, sched, rob, prf, sch, exp_fire, exp_code}
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b1,1'b1,5'd2, 5'd1,5'd1,7'd60,7'd60,7'd60,1'b1,2'd0}, // R4 fresh cycle
        {1'b0,1'b1,5'd2, 5'd1,5'd1,7'd60,7'd60,7'd60,1'b1,2'd0}, // R4 second in cycle
        {1'b0,1'b1,5'd1, 5'd1,5'd1,7'd60,7'd60,7'd60,1'b0,2'd0}, // R4 no slots left
        {1'b1,1'b1,5'd1, 5'd1,5'd1,7'd0, 7'd60,7'd60,1'b0,2'd1}, // R2 rob short
        {1'b0,1'b1,5'd4, 5'd2,5'd1,7'd60,7'd1, 7'd60,1'b0,2'd2}, // R2 prf short
        {1'b0,1'b1,5'd4, 5'd2,5'd3,7'd60,7'd60,7'd2, 1'b0,2'd3}, // R2 sch short
        {1'b0,1'b1,5'd4, 5'd2,5'd1,7'd3, 7'd0, 7'd0, 1'b0,2'd1}, // R2 priority rob
        {1'b0,1'b1,5'd4, 5'd2,5'd1,7'd60,7'd1, 7'd0, 1'b0,2'd2}, // R2 priority prf
        {1'b0,1'b1,5'd4, 5'd2,5'd1,7'd60,7'd60,7'd60,1'b1,2'd0}, // R8 slots kept
        {1'b1,1'b1,5'd10,5'd3,5'd2,7'd60,7'd60,7'd60,1'b1,2'd0}, // R5 wide, carry 6
        {1'b1,1'b1,5'd1, 5'd1,5'd1,7'd60,7'd60,7'd60,1'b0,2'd0}, // R5 refill 0
        {1'b1,1'b1,5'd1, 5'd1,5'd1,7'd60,7'd60,7'd60,1'b1,2'd0}, // R5 refill 2
        {1'b0,1'b1,5'd2, 5'd1,5'd1,7'd60,7'd60,7'd60,1'b0,2'd0}, // R4 one slot left
        {1'b1,1'b1,5'd5, 5'd1,5'd1,7'd60,7'd60,7'd60,1'b1,2'd0}, // R5 carry 1
        {1'b1,1'b1,5'd3, 5'd1,5'd1,7'd60,7'd60,7'd60,1'b1,2'd0}, // R5 refill 3
        {1'b1,1'b0,5'd1, 5'd1,5'd1,7'd0, 7'd0, 7'd0, 1'b0,2'd0}, // R9 idle
        {1'b0,1'b1,5'd4, 5'd2,5'd1,7'd4, 7'd2, 7'd1, 1'b1,2'd0}, // R1 exact fit
        {1'b1,1'b1,5'd3, 5'd0,5'd0,7'd2, 7'd60,7'd60,1'b0,2'd1}  // R1 one short
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic drive(input bit b, input bit v, input int u, input int d, input int s,
                         input int rf, input int pf, input int sf);
        cyc_begin  = b;
        head_valid = v;
        head_uops  = NEED_W'(u);
        head_dsts  = NEED_W'(d);
        head_sched = NEED_W'(s);
        rob_free   = FREE_W'(rf);
        prf_free   = FREE_W'(pf);
        sch_free   = FREE_W'(sf);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int e1, e2, e3;
        e1 = 0; e2 = 0; e3 = 0;
        do_reset();
        #1;
        // R7 reset state
        chk(stall_cnt_rob == 0 && stall_cnt_prf == 0 && stall_cnt_sch == 0,
            "R7 counters after reset", int'(stall_cnt_rob), 0);
        chk(!disp_fire && stall_code == 0, "R9 idle after reset", int'(disp_fire), 0);
        drive(0, 1, 4, 1, 1, 60, 60, 60);
        #1 chk(disp_fire == 1'b1, "R7 full width without refill", int'(disp_fire), 1);

        for (int i = 0; i < NVEC; i++) begin
            logic [40:0] v;
            v = VEC[i];
            @(posedge clk);
            #1 drive(v[40], v[39], int'(v[38:34]), int'(v[33:29]), int'(v[28:24]),
                     int'(v[23:17]), int'(v[16:10]), int'(v[9:3]));
            #1;
            chk(disp_fire == v[2], $sformatf("R1/R4/R5 fire vec %0d", i),
                int'(disp_fire), int'(v[2]));
            chk(stall_code == v[1:0], $sformatf("R2 code vec %0d", i),
                int'(stall_code), int'(v[1:0]));
            chk(alloc_rob == (v[2] ? v[38:34] : 5'd0) && alloc_prf == (v[2] ? v[33:29] : 5'd0)
                && alloc_sch == (v[2] ? v[28:24] : 5'd0),
                $sformatf("R3 alloc vec %0d", i), int'(alloc_rob), v[2] ? int'(v[38:34]) : 0);
            if (v[1:0] == 2'd1) e1++;
            if (v[1:0] == 2'd2) e2++;
            if (v[1:0] == 2'd3) e3++;
        end
        @(posedge clk);
        #1 drive(0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        chk(int'(stall_cnt_rob) == e1, "R6 rob counter", int'(stall_cnt_rob), e1);
        chk(int'(stall_cnt_prf) == e2, "R6 prf counter", int'(stall_cnt_prf), e2);
        chk(int'(stall_cnt_sch) == e3, "R6 sch counter", int'(stall_cnt_sch), e3);

        // R7 mid-run reset, then a wide instruction without refill
        do_reset();
        #1 chk(stall_cnt_rob == 0 && stall_cnt_prf == 0 && stall_cnt_sch == 0,
               "R7 counters cleared", int'(stall_cnt_rob), 0);
        drive(0, 1, 5, 1, 1, 60, 60, 60);
        #1 chk(disp_fire == 1'b1, "R7 wide dispatch after reset", int'(disp_fire), 1);
        @(posedge clk);
        #1 drive(0, 1, 1, 1, 1, 60, 60, 60);
        #1 chk(disp_fire == 1'b0, "R5 carry blocks same cycle", int'(disp_fire), 0);
        @(posedge clk);
        #1 drive(1, 1, 3, 1, 1, 60, 60, 60);
        #1 chk(disp_fire == 1'b1, "R5 refill W minus carry", int'(disp_fire), 1);
        @(posedge clk);
        #1 drive(0, 1, 1, 1, 1, 60, 60, 60);
        #1 chk(disp_fire == 1'b0, "R5 refill was only three", int'(disp_fire), 0);

        // R6 saturation under a held reorder-buffer stall
        @(posedge clk);
        #1 drive(1, 1, 1, 1, 1, 0, 60, 60);
        repeat (20) @(posedge clk);
        #1;
        chk(stall_cnt_rob == '1, "R6 saturation", int'(stall_cnt_rob), (1 << CNT_W) - 1);
        chk(stall_cnt_prf == 0 && stall_cnt_sch == 0, "R6 other counters held",
            int'(stall_cnt_prf), 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        finish_run();
    end

endmodule